// File: doc/BRIEF.md
# Packed Binary64 Predicate Comparator

This block compares two packed vectors of binary64 floating-point elements lane by lane. For each lane it evaluates one relation chosen by a five-bit predicate code and writes a full-width mask element: all ones when the predicate holds, all zeros when it does not. Operands are treated as sign-magnitude floating-point values. Positive and negative zero are equal, and a larger magnitude is lower when the sign is negative.

The predicate code has three parts. The first is the relation tested on ordered lanes, with an optional inversion. The second is the result forced on unordered lanes, meaning lanes where either operand is a NaN. The third is a quiet or signalling choice that decides which NaNs raise the invalid-operation condition. Per-lane invalid conditions are ORed into a sticky flag, which only reset clears. A NaN in one lane has no effect on any other lane. A compare is taken on a clock edge where `cmp_go` is high. By default the mask is registered and holds its value between compares.

Top module: `fpcmp_packed`

## Requirements
- R1: After reset, `mask_out` is all zeros and `inval_sticky` is 0.
- R2: With `REG_OUT`=1, the mask for a compare appears on the clock edge that samples `cmp_go`=1. Every element is either all ones or all zeros. The mask does not change on edges where `cmp_go`=0.
- R3: The predicate code fields are: bits [1:0] select the relation (0 equal, 1 less-than, 2 less-or-equal, 3 never-true), bit 2 inverts that relation on ordered lanes, bit 3 is the result on unordered lanes, and bit 4 selects signalling behaviour.
- R4: Ordering follows sign-magnitude semantics. Any negative value is below any positive value, and among negatives the larger magnitude is lower.
- R5: Positive zero and negative zero compare equal in every relation, and neither is less than the other.
- R6: An unordered lane (either operand a NaN: exponent all ones, mantissa nonzero) yields the code's bit 3 for every relation, whatever the inversion bit. Relation 3 with bit 3 set therefore tests "unordered", and relation 3 with bits 2 set and 3 clear tests "ordered".
- R7: With bit 4 clear, a lane raises invalid only if an operand is a signalling NaN, meaning a NaN with mantissa bit 51 clear. Quiet NaNs (mantissa bit 51 set) raise nothing.
- R8: With bit 4 set, a lane raises invalid if either operand is any NaN.
- R9: `inval_sticky` is set by any lane's invalid condition during a compare and stays set until reset. Compares without invalid lanes do not clear it.
- R10: Each lane's mask depends only on that lane's operands. A NaN in one lane leaves the other lanes' results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_go | input | 1 | Take a compare on this edge |
| pred_code | input | 5 | Predicate code (relation, invert, unordered result, signalling) |
| opa | input | LANES*64 | First operand vector, lane 0 in the low bits |
| opb | input | LANES*64 | Second operand vector, lane 0 in the low bits |
| mask_out | output | LANES*64 | Per-lane all-ones / all-zeros result |
| inval_sticky | output | 1 | Sticky invalid-operation flag |

## Verification
The bench uses negative operands whose raw bit patterns order the other way as integers, so a comparator that treats lanes as unsigned would flip those lanes. Signed zeros are compared under equal, less-than and less-or-equal; a design that compares raw bits would call them unequal or order them. NaN lanes sit next to ordered lanes under both inverted and plain predicates, which catches a design that inverts the unordered result or lets a NaN disturb its neighbours. Quiet and signalling NaNs are applied under both quiet and signalling codes, so a design that swaps the NaN classes or ignores the signalling bit sets the sticky flag wrongly. The bench also checks that the flag stays set through later clean compares.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

   localparam int PRED_W = 5;

   typedef enum logic [1:0] {
      REL_EQ   = 2'd0,
      REL_LT   = 2'd1,
      REL_LE   = 2'd2,
      REL_NONE = 2'd3
   } rel_e;

   typedef struct packed {
      logic sig;
      logic unord_val;
      logic neg;
      rel_e rel;
   } pred_s;

   typedef struct packed {
      logic sign;
      logic is_zero;
      logic is_nan;
      logic is_snan;
   } cls_s;

   function automatic pred_s decode_pred(input logic [PRED_W-1:0] code);
      pred_s p;
      p.rel       = rel_e'(code[1:0]);
      p.neg       = code[2];
      p.unord_val = code[3];
      p.sig       = code[4];
      return p;
   endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
   import fpcmp_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int ELEM_W = 1 + EXP_W + MAN_W,
   localparam int MAG_W  = EXP_W + MAN_W
) (
   input  logic [ELEM_W-1:0] val,
   output cls_s              cls,
   output logic [MAG_W-1:0]  mag
);

   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] mant;

   always_comb begin
      expo        = val[MAN_W +: EXP_W];
      mant        = val[MAN_W-1:0];
      mag         = val[MAG_W-1:0];
      cls.sign    = val[ELEM_W-1];
      cls.is_zero = ~|mag;
      cls.is_nan  = (&expo) & (|mant);
      cls.is_snan = cls.is_nan & ~mant[MAN_W-1];
   end

endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
   import fpcmp_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int ELEM_W = 1 + EXP_W + MAN_W,
   localparam int MAG_W  = EXP_W + MAN_W
) (
   input  logic [ELEM_W-1:0] a,
   input  logic [ELEM_W-1:0] b,
   input  pred_s             pred,
   output logic              hit,
   output logic              inval
);

   cls_s             ca, cb;
   logic [MAG_W-1:0] ma, mb;
   logic             ordered, both_zero, eq, lt, rel_val;

   fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
      .val (a),
      .cls (ca),
      .mag (ma)
   );

   fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
      .val (b),
      .cls (cb),
      .mag (mb)
   );

   always_comb begin
      ordered   = ~(ca.is_nan | cb.is_nan);
      both_zero = ca.is_zero & cb.is_zero;
      eq        = both_zero | (a == b);
      if (both_zero)
         lt = 1'b0;
      else if (ca.sign != cb.sign)
         lt = ca.sign;
      else if (ca.sign)
         lt = (mb < ma);
      else
         lt = (ma < mb);

      unique case (pred.rel)
         REL_EQ:   rel_val = eq;
         REL_LT:   rel_val = lt;
         REL_LE:   rel_val = lt | eq;
         default:  rel_val = 1'b0;
      endcase

      hit   = ordered ? (rel_val ^ pred.neg) : pred.unord_val;
      inval = pred.sig ? (ca.is_nan | cb.is_nan) : (ca.is_snan | cb.is_snan);
   end

endmodule

// File: rtl/fpcmp_packed.sv
module fpcmp_packed
   import fpcmp_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int EXP_W   = 11,
   parameter int MAN_W   = 52,
   parameter int REG_OUT = 1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cmp_go,
   input  logic [4:0]                           pred_code,
   input  logic [LANES*(1+EXP_W+MAN_W)-1:0]     opa,
   input  logic [LANES*(1+EXP_W+MAN_W)-1:0]     opb,
   output logic [LANES*(1+EXP_W+MAN_W)-1:0]     mask_out,
   output logic                                 inval_sticky
);

   localparam int ELEM_W = 1 + EXP_W + MAN_W;
   localparam int VEC_W  = LANES * ELEM_W;

   generate
      if (LANES < 1)              begin : g_bad_lanes  $error("LANES must be at least 1");    end
      if (EXP_W < 2)              begin : g_bad_exp    $error("EXP_W must be at least 2");    end
      if (MAN_W < 2)              begin : g_bad_man    $error("MAN_W must be at least 2");    end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg $error("REG_OUT must be 0 or 1"); end
   endgenerate

   pred_s             pred;
   logic [LANES-1:0]  lane_hit;
   logic [LANES-1:0]  lane_inval;
   logic [VEC_W-1:0]  mask_d;
   logic              inval_any;

   assign pred = decode_pred(pred_code);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         fpcmp_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
            .a     (opa[l*ELEM_W +: ELEM_W]),
            .b     (opb[l*ELEM_W +: ELEM_W]),
            .pred  (pred),
            .hit   (lane_hit[l]),
            .inval (lane_inval[l])
         );
         assign mask_d[l*ELEM_W +: ELEM_W] = {ELEM_W{lane_hit[l]}};
      end
   endgenerate

   assign inval_any = cmp_go & (|lane_inval);

   always_ff @(posedge clk) begin
      if (!rst_n)
         inval_sticky <= 1'b0;
      else if (inval_any)
         inval_sticky <= 1'b1;
   end

   generate
      if (REG_OUT == 1) begin : g_reg_mask
         logic [VEC_W-1:0] mask_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               mask_q <= '0;
            else if (cmp_go)
               mask_q <= mask_d;
         end
         assign mask_out = mask_q;
      end else begin : g_comb_mask
         assign mask_out = mask_d;
      end
   endgenerate

endmodule

// File: rtl/fpcmp_packed_chk.sv
module fpcmp_packed_chk #(
   parameter int LANES   = 4,
   parameter int EXP_W   = 11,
   parameter int MAN_W   = 52,
   parameter int REG_OUT = 1,
   localparam int ELEM_W = 1 + EXP_W + MAN_W,
   localparam int VEC_W  = LANES * ELEM_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmp_go,
   input logic             pred_unord,
   input logic             pred_sig,
   input logic [VEC_W-1:0] opa,
   input logic [VEC_W-1:0] opb,
   input logic [VEC_W-1:0] mask_out,
   input logic             inval_sticky
);

   logic [LANES-1:0] nan_lane;
   logic [LANES-1:0] snan_lane;

   function automatic logic elem_nan(input logic [ELEM_W-1:0] e);
      return (&e[MAN_W +: EXP_W]) & (|e[MAN_W-1:0]);
   endfunction

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         nan_lane[l]  = elem_nan(opa[l*ELEM_W +: ELEM_W]) | elem_nan(opb[l*ELEM_W +: ELEM_W]);
         snan_lane[l] = (elem_nan(opa[l*ELEM_W +: ELEM_W]) & ~opa[l*ELEM_W + MAN_W-1])
                      | (elem_nan(opb[l*ELEM_W +: ELEM_W]) & ~opb[l*ELEM_W + MAN_W-1]);
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask_out == '0) && !inval_sticky); // R1

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      inval_sticky |=> inval_sticky); // R9

   AST_SIG_NAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_go && pred_sig && (|nan_lane)) |=> inval_sticky); // R8

   AST_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_go && !pred_sig && !(|snan_lane) && !inval_sticky) |=> !inval_sticky); // R7

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_chk
         AST_MASK_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_out[l*ELEM_W +: ELEM_W] == '0) || (&mask_out[l*ELEM_W +: ELEM_W])); // R2
         if (REG_OUT == 1) begin : g_reg
            AST_UNORD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
               (cmp_go && nan_lane[l]) |=> (mask_out[l*ELEM_W +: ELEM_W] == {ELEM_W{$past(pred_unord)}})); // R6
         end
      end
      if (REG_OUT == 1) begin : g_hold
         AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !cmp_go |=> $stable(mask_out)); // R2
      end
   endgenerate

endmodule

bind fpcmp_packed fpcmp_packed_chk #(
   .LANES(LANES), .EXP_W(EXP_W), .MAN_W(MAN_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmp_go       (cmp_go),
   .pred_unord   (pred_code[3]),
   .pred_sig     (pred_code[4]),
   .opa          (opa),
   .opb          (opb),
   .mask_out     (mask_out),
   .inval_sticky (inval_sticky)
);

// File: tb/fpcmp_packed_bench.sv
module fpcmp_packed_bench;

   localparam int LANES = 4;
   localparam int EW    = 64;
   localparam int VW    = LANES * EW;

   localparam logic [63:0] P1   = 64'h3FF0000000000000;
   localparam logic [63:0] P2   = 64'h4000000000000000;
   localparam logic [63:0] N1   = 64'hBFF0000000000000;
   localparam logic [63:0] N2   = 64'hC000000000000000;
   localparam logic [63:0] PZ   = 64'h0000000000000000;
   localparam logic [63:0] NZ   = 64'h8000000000000000;
   localparam logic [63:0] QN   = 64'h7FF8000000000000;
   localparam logic [63:0] SN   = 64'h7FF0000000000001;
   localparam logic [63:0] PINF = 64'h7FF0000000000000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmp_go = 1'b0;
   logic [4:0]    pred_code = '0;
   logic [VW-1:0] opa = '0, opb = '0;
   logic [VW-1:0] mask_out;
   logic          inval_sticky;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   fpcmp_packed u_fpcmp_packed (
      .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .pred_code(pred_code),
      .opa(opa), .opb(opb), .mask_out(mask_out), .inval_sticky(inval_sticky)
   );

   function automatic logic [4:0] pc(input int rel, input bit neg, input bit unord, input bit sig);
      return {sig, unord, neg, rel[1:0]};
   endfunction

   function automatic logic [VW-1:0] spread(input logic [LANES-1:0] bits);
      logic [VW-1:0] v;
      for (int l = 0; l < LANES; l++) v[l*EW +: EW] = {EW{bits[l]}};
      return v;
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; cmp_go = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic apply(input logic [4:0] code, input logic [VW-1:0] a, input logic [VW-1:0] b);
      @(negedge clk);
      pred_code = code; opa = a; opb = b; cmp_go = 1'b1;
      @(negedge clk);
      cmp_go = 1'b0;
   endtask

   task automatic chk_mask(input string tag, input logic [LANES-1:0] exp_bits);
      n_vec++;
      if (mask_out !== spread(exp_bits)) begin
         n_bad++;
         $display("FAIL %s mask act=%h exp=%h", tag, mask_out, spread(exp_bits));
      end
   endtask

   task automatic chk_flag(input string tag, input logic exp_f);
      n_vec++;
      if (inval_sticky !== exp_f) begin
         n_bad++;
         $display("FAIL %s inval act=%0b exp=%0b", tag, inval_sticky, exp_f);
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk_mask("R1 reset", 4'b0000);
      chk_flag("R1 reset", 1'b0);
   endtask

   task automatic t_equal();
      apply(pc(0,0,0,0), {PZ, N1, P2, P1}, {NZ, N1, P1, P1});
      chk_mask("R3 R5 equal", 4'b1101);
   endtask

   task automatic t_sign_order();
      apply(pc(1,0,0,0), {N1, P1, N1, N2}, {P1, P2, N2, N1});
      chk_mask("R4 less-than signs", 4'b1101);
   endtask

   task automatic t_le_zero();
      apply(pc(2,0,0,0), {NZ, PZ, P2, P1}, {PZ, NZ, P1, P1});
      chk_mask("R3 R5 less-or-equal", 4'b1101);
      apply(pc(1,0,0,0), {NZ, PZ, NZ, PZ}, {PZ, NZ, PZ, NZ});
      chk_mask("R5 zero not less", 4'b0000);
   endtask

   task automatic t_quiet_nan();
      apply(pc(1,0,0,0), {P2, QN, P1, QN}, {P1, P1, P2, P1});
      chk_mask("R10 R6 ordered quiet lt", 4'b0010);
      chk_flag("R7 quiet nan no flag", 1'b0);
   endtask

   task automatic t_sig_negated();
      apply(pc(1,1,1,1), {P2, QN, P1, QN}, {P1, P1, P2, P1});
      chk_mask("R6 R10 not-lt unordered", 4'b1101);
      chk_flag("R8 signalling any nan", 1'b1);
   endtask

   task automatic t_sticky_hold();
      apply(pc(0,0,0,0), {P1, P1, P1, P1}, {P1, P1, P1, P1});
      chk_flag("R9 sticky holds", 1'b1);
      @(negedge clk); opa = '0; opb = {4{QN}}; pred_code = pc(3,1,0,1);
      @(negedge clk);
      chk_mask("R2 idle hold", 4'b1111);
   endtask

   task automatic t_unord_pred();
      do_reset();
      apply(pc(3,0,1,0), {PINF, SN, P1, QN}, {PINF, P1, P1, P1});
      chk_mask("R6 unordered predicate", 4'b0101);
      chk_flag("R7 quiet snan flags", 1'b1);
      do_reset();
      apply(pc(3,1,0,0), {PINF, QN, P1, QN}, {PINF, P1, P1, QN});
      chk_mask("R6 ordered predicate", 4'b1010);
      chk_flag("R7 quiet qnan only", 1'b0);
   endtask

   initial begin
      t_reset();
      t_equal();
      t_sign_order();
      t_le_zero();
      t_quiet_nan();
      t_sig_negated();
      t_sticky_hold();
      t_unord_pred();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule